// File: doc/BRIEF.md
# ADC Result Formatter and Tagger

This block sits between the output of an analog-to-digital converter core and a result queue. It accepts one raw 12-bit conversion code per handshake. It applies a gain and offset correction on its own, with no software step. It clamps the corrected value to the converter's code range and reduces it to the resolution that the command asked for. It then emits the value as a right-justified word, either unsigned or signed relative to midscale.

Each result can be followed by a timestamp word. The time value comes from one of two places: an external time bus, or a 16-bit counter kept inside the block that advances on a strobe. The resolution, format, correction constants and timestamp choices are all taken in the same cycle as the raw code. A command therefore carries its own settings, and later changes to them do not affect it. The output is a valid/ready stream that holds its word under backpressure and never loses a result.

Top module: `adc_result_shaper`

## Requirements
- R1: The corrected value is floor(raw × gain / 2^14) + offset. Gain is a 16-bit unsigned number with 14 fraction bits. Offset is a 14-bit two's complement number.
- R2: The corrected value is clamped to the range 0 to 4095 before any resolution reduction.
- R3: cfg_res selects the resolution: 0 gives 8 bits, 1 gives 10 bits, 2 or 3 gives 12 bits. Reduction drops the low bits of the clamped 12-bit value, that is, a right shift by 4, 2 or 0.
- R4: With cfg_signed = 0, the result word is the reduced value zero-extended to 16 bits.
- R5: With cfg_signed = 1, the result word is the reduced value minus 2^(N-1), where N is the chosen resolution, sign-extended to 16 bits. Midscale therefore maps to zero.
- R6: With cfg_ts_en = 1, a second word carrying the timestamp is emitted directly after the result word, with out_is_time = 1. The result word always has out_is_time = 0. With cfg_ts_en = 0, only the result word is emitted.
- R7: cfg_ts_sel = 1 stamps the value on ext_time in the accept cycle. cfg_ts_sel = 0 stamps the internal counter. A later change of ext_time does not alter a captured stamp.
- R8: The internal counter is 16 bits wide, increments at each clock edge where tick = 1, and wraps from 0xFFFF to 0. The stamp is the counter value before the increment in the accept cycle.
- R9: While out_valid = 1 and out_ready = 0, the output word and tag are held stable and raw_ready = 0. No accepted result or timestamp is lost.
- R10: The raw code and all cfg_* inputs are sampled only in the cycle where raw_valid and raw_ready are both 1.
- R11: After reset, out_valid = 0, raw_ready = 1 and the internal counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_valid | input | 1 | Raw code present |
| raw_ready | output | 1 | Block can take a raw code |
| raw_code | input | 12 | Raw conversion code |
| cfg_gain | input | 16 | Gain, unsigned, 14 fraction bits |
| cfg_offset | input | 14 | Offset, two's complement |
| cfg_res | input | 2 | Resolution select |
| cfg_signed | input | 1 | 1 = signed result format |
| cfg_ts_en | input | 1 | 1 = append timestamp word |
| cfg_ts_sel | input | 1 | 1 = external time, 0 = internal counter |
| ext_time | input | 16 | External time value |
| tick | input | 1 | Internal counter increment strobe |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts output word |
| out_word | output | 16 | Result or timestamp word |
| out_is_time | output | 1 | 1 = out_word is a timestamp |

## Verification
On every cycle, the assertions check four things. The output word and tag must hold while stalled. The input must be closed while the output is stalled. A timestamp word may only appear right after its result word or while it is itself held. The internal counter must advance by one on each tick.

The arithmetic needs the bench's scenarios to show it: the correction, the clamping at both ends, and every resolution and format pair. The same holds for the choice of time source, counter wrap, capture at the accept instant, and the ordering of a second command that waits behind a stalled one.

// File: rtl/adc_result_shaper.sv
module adc_result_shaper #(
  parameter int RAW_W  = 12,
  parameter int GAIN_W = 16,
  parameter int FRAC_W = 14,
  parameter int OFS_W  = 14,
  parameter int W      = 16,
  parameter int DROP_A = 4,
  parameter int DROP_B = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_valid,
  output logic             raw_ready,
  input  logic [RAW_W-1:0] raw_code,
  input  logic [GAIN_W-1:0] cfg_gain,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic [1:0]       cfg_res,
  input  logic             cfg_signed,
  input  logic             cfg_ts_en,
  input  logic             cfg_ts_sel,
  input  logic [W-1:0]     ext_time,
  input  logic             tick,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_word,
  output logic             out_is_time
);
  localparam int PROD_W = RAW_W + GAIN_W;
  localparam int SCL_W  = PROD_W - FRAC_W;
  localparam int SUM_W  = ((SCL_W > OFS_W) ? SCL_W : OFS_W) + 2;

  logic [PROD_W-1:0]       prod;
  logic [SCL_W-1:0]        scaled;
  logic signed [SUM_W-1:0] sum;
  logic [RAW_W-1:0]        clamped, reduced, mid;
  logic [W-1:0]            fmt, stamp, ts_hold, ts_cnt;
  logic                    pend, take, fire;
  int unsigned             drop;

  assign prod   = raw_code * cfg_gain;
  assign scaled = prod[PROD_W-1:FRAC_W];
  assign sum    = $signed({{(SUM_W-SCL_W){1'b0}}, scaled})
                + $signed({{(SUM_W-OFS_W){cfg_offset[OFS_W-1]}}, cfg_offset});

  always_comb begin
    if (sum[SUM_W-1])               clamped = '0;
    else if (|sum[SUM_W-2:RAW_W])   clamped = '1;
    else                            clamped = sum[RAW_W-1:0];
    case (cfg_res)
      2'd0:    drop = DROP_A;
      2'd1:    drop = DROP_B;
      default: drop = 0;
    endcase
    reduced = clamped >> drop;
    mid     = RAW_W'(1) << (RAW_W - 1 - drop);
    fmt     = {{(W-RAW_W){1'b0}}, reduced};
    if (cfg_signed) fmt = fmt - {{(W-RAW_W){1'b0}}, mid};
  end

  assign stamp     = cfg_ts_sel ? ext_time : ts_cnt;
  assign fire      = out_valid && out_ready;
  assign raw_ready = !out_valid || (out_ready && !pend);
  assign take      = raw_valid && raw_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    ts_cnt <= '0;
    else if (tick) ts_cnt <= ts_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_is_time <= 1'b0;
      pend        <= 1'b0;
      ts_hold     <= '0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_word    <= fmt;
      out_is_time <= 1'b0;
      pend        <= cfg_ts_en;
      ts_hold     <= stamp;
    end else if (fire) begin
      if (pend) begin
        out_word    <= ts_hold;
        out_is_time <= 1'b1;
        pend        <= 1'b0;
      end else begin
        out_valid   <= 1'b0;
        out_is_time <= 1'b0;
      end
    end
  end
endmodule

module adc_result_shaper_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         raw_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_word,
  input logic         out_is_time,
  input logic         tick,
  input logic [W-1:0] ts_cnt
);
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_is_time)));

  a_r9_closed_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !raw_ready);

  a_r6_time_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_time) |->
      ($past(out_valid && out_ready && !out_is_time) || $past(out_valid && !out_ready && out_is_time)));

  a_r8_tick_count: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (ts_cnt == $past(ts_cnt) + 16'd1));
endmodule

bind adc_result_shaper adc_result_shaper_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .raw_ready(raw_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word), .out_is_time(out_is_time),
  .tick(tick), .ts_cnt(ts_cnt)
);

// File: tb/adc_result_shaper_tb_top.sv
module adc_result_shaper_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        raw_valid = 0, out_ready = 1, tick = 0;
  logic        cfg_signed = 0, cfg_ts_en = 0, cfg_ts_sel = 0;
  logic [11:0] raw_code = 0;
  logic [15:0] cfg_gain = 16'h4000, ext_time = 0;
  logic [13:0] cfg_offset = 0;
  logic [1:0]  cfg_res = 2;
  logic        raw_ready, out_valid, out_is_time;
  logic [15:0] out_word;
  int errors = 0, checks = 0, cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_result_shaper dut_i (
    .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_ready(raw_ready),
    .raw_code(raw_code), .cfg_gain(cfg_gain), .cfg_offset(cfg_offset),
    .cfg_res(cfg_res), .cfg_signed(cfg_signed), .cfg_ts_en(cfg_ts_en),
    .cfg_ts_sel(cfg_ts_sel), .ext_time(ext_time), .tick(tick),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_is_time(out_is_time)
  );

  typedef struct packed {
    logic [11:0] raw; logic [15:0] gain; logic [13:0] off;
    logic [1:0] res; logic sgn; logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{12'h800, 16'h4000, 14'h0000, 2'd2, 1'b0, 16'h0800},
    '{12'h800, 16'h4000, 14'h0000, 2'd2, 1'b1, 16'h0000},
    '{12'h000, 16'h4000, 14'h0000, 2'd2, 1'b1, 16'hF800},
    '{12'hFFF, 16'h4000, 14'h0000, 2'd3, 1'b1, 16'h07FF},
    '{12'hFFF, 16'h4000, 14'h0000, 2'd0, 1'b0, 16'h00FF},
    '{12'hFFF, 16'h4000, 14'h0000, 2'd0, 1'b1, 16'h007F},
    '{12'h123, 16'h4000, 14'h0000, 2'd1, 1'b0, 16'h0048},
    '{12'h000, 16'h4000, 14'h0000, 2'd1, 1'b1, 16'hFE00},
    '{12'hF00, 16'h8000, 14'h0000, 2'd2, 1'b0, 16'h0FFF},
    '{12'h010, 16'h4000, 14'h3FE0, 2'd2, 1'b0, 16'h0000},
    '{12'h400, 16'h2000, 14'h0010, 2'd2, 1'b0, 16'h0210},
    '{12'h400, 16'h6000, 14'h0000, 2'd0, 1'b1, 16'hFFE0},
    '{12'h7FF, 16'h4000, 14'h0001, 2'd1, 1'b1, 16'h0000}
  };

  function automatic logic [15:0] model(input logic [11:0] raw, input logic [15:0] gain,
                                        input logic [13:0] off, input logic [1:0] res,
                                        input logic sgn);
    int v, bits;
    v = int'((longint'(raw) * longint'(gain)) >>> 14) + int'($signed(off));
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    bits = (res == 0) ? 8 : (res == 1) ? 10 : 12;
    v = v >> (12 - bits);
    if (sgn) v = v - (1 << (bits - 1));
    return v[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] raw, input logic [15:0] gain, input logic [13:0] off,
                      input logic [1:0] res, input logic sgn, input logic tsen, input logic tssel,
                      input logic [15:0] exp_w, input logic [15:0] exp_t, input string req);
    @(negedge clk);
    raw_code = raw; cfg_gain = gain; cfg_offset = off; cfg_res = res;
    cfg_signed = sgn; cfg_ts_en = tsen; cfg_ts_sel = tssel; raw_valid = 1;
    @(negedge clk);
    raw_valid = 0;
    ext_time = ext_time ^ 16'h5A5A;
    chk(out_valid && !out_is_time && out_word == exp_w, req, out_word, exp_w);
    if (tsen) begin
      @(negedge clk);
      chk(out_valid && out_is_time && out_word == exp_t, {req, " R6 ts"}, out_word, exp_t);
    end
    @(negedge clk);
    chk(!out_valid, {req, " R6 end"}, out_valid, 0);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
    cnt = (cnt + n) % 65536;
  endtask

  initial begin
    #(4 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && raw_ready, "R11 reset", {out_valid, raw_ready}, 1);
    rst_n = 1;
    send(12'h0, 16'h4000, 14'h0, 2'd2, 0, 1, 0, 16'h0, 16'h0, "R11 counter zero");

    foreach (VEC[i])
      send(VEC[i].raw, VEC[i].gain, VEC[i].off, VEC[i].res, VEC[i].sgn, 0, 0,
           VEC[i].exp, 0, $sformatf("R1 R2 R3 R4 R5 vec%0d", i));

    for (int i = 0; i < 200; i++) begin
      logic [11:0] r; logic [15:0] g; logic [13:0] o; logic [1:0] s; logic sg;
      r = 12'($urandom); g = 16'($urandom); o = 14'($urandom); s = 2'($urandom); sg = 1'($urandom);
      if (i % 2 == 0) o = {{4{o[9]}}, o[9:0]};
      send(r, g, o, s, sg, 0, 0, model(r, g, o, s, sg), 0, "R1 R3 R5 random");
    end

    ticks(5);
    send(12'h800, 16'h4000, 14'h0, 2'd2, 0, 1, 0, 16'h0800, 16'(cnt), "R8 internal stamp");
    ext_time = 16'hBEEF;
    send(12'h800, 16'h4000, 14'h0, 2'd2, 1, 1, 1, 16'h0000, 16'hBEEF, "R7 external stamp");

    @(negedge clk);
    raw_code = 12'hFFF; cfg_gain = 16'h4000; cfg_offset = 0; cfg_res = 2;
    cfg_signed = 0; cfg_ts_en = 1; cfg_ts_sel = 0; raw_valid = 1; tick = 1;
    @(negedge clk);
    raw_valid = 0; tick = 0;
    chk(out_word == 16'h0FFF, "R8 accept with tick", out_word, 16'h0FFF);
    @(negedge clk);
    chk(out_is_time && out_word == 16'(cnt), "R8 pre-increment stamp", out_word, cnt);
    cnt = (cnt + 1) % 65536;
    @(negedge clk);

    ticks(65535 - cnt);
    send(12'h0, 16'h4000, 14'h0, 2'd2, 0, 1, 0, 16'h0, 16'hFFFF, "R8 at max");
    ticks(1);
    send(12'h0, 16'h4000, 14'h0, 2'd2, 0, 1, 0, 16'h0, 16'h0000, "R8 wrap");

    out_ready = 0;
    @(negedge clk);
    raw_code = 12'h100; cfg_gain = 16'h4000; cfg_offset = 0; cfg_res = 2;
    cfg_signed = 0; cfg_ts_en = 1; cfg_ts_sel = 1; ext_time = 16'h1234; raw_valid = 1;
    @(negedge clk);
    raw_code = 12'h200; cfg_ts_en = 0; cfg_res = 0;
    ext_time = 16'h9999;
    repeat (3) begin
      chk(out_valid && !out_is_time && out_word == 16'h0100 && !raw_ready,
          "R9 held under stall", out_word, 16'h0100);
      @(negedge clk);
    end
    out_ready = 1;
    @(negedge clk);
    chk(out_is_time && out_word == 16'h1234, "R9 R10 stamp after stall", out_word, 16'h1234);
    @(negedge clk);
    raw_valid = 0;
    chk(out_valid && !out_is_time && out_word == 16'h0020, "R9 R10 second result kept",
        out_word, 16'h0020);
    @(negedge clk);
    chk(!out_valid, "R6 no stamp when disabled", out_valid, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule